// File: doc/BRIEF.md
# Parallel Self-Synchronizing Payload Descrambler

This block undoes a multiplicative scrambler applied to the 64-bit payload of each 66-bit line block. One payload word is processed per clock, whenever the input strobe is high. The 2-bit sync header travels beside the payload and comes out as it went in. The descrambled payload appears one clock later, with its own valid strobe.

The block keeps a 58-bit history of the most recently received scrambled bits. Every output bit is the matching input bit XORed with the scrambled bits received 39 and 58 positions earlier, which gives the polynomial 1 + x^39 + x^58. The history is filled only from received line bits, so the block locks on by itself: after any 58 received payload bits its output is correct, whatever the history held at reset.

A bypass control makes the payload pass through unchanged. The history keeps tracking the line while bypass is on, so the first word after bypass is dropped is already descrambled correctly.

Top module: `payload_descrambler`

## Requirements
- R1: While reset is asserted, and after it until the first valid word, `outValid` is 0 and both `outHeader` and `outPayload` are all zeros.
- R2: `outValid` equals `inValid` delayed by exactly one clock, and each result appears one clock after its input word.
- R3: `outHeader` equals the `inHeader` of the same word for every 2-bit value, the invalid codes 00 and 11 included.
- R4: Bit 0 of a payload word is the earliest bit on the line. Output bit i is input bit i XOR the scrambled bits received 39 and 58 positions before it, with bits counted in line order across word boundaries. The result equals 64 serial steps taken from bit 0 to bit 63.
- R5: Once at least 58 payload bits have been received since reset, the output equals the plaintext that the matching scrambler encoded, whatever the history held at reset.
- R6: The scrambled-bit history advances only on cycles where `inValid` is 1. Gaps of any length between words leave the descrambled stream unchanged.
- R7: When `bypassEn` is 1 with a valid word, `outPayload` equals `inPayload` bit for bit.
- R8: The history keeps taking in received bits during bypass, so the first word after bypass ends is descrambled correctly.
- R9: On a clock where `inValid` is 0, `outHeader` and `outPayload` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input word strobe |
| inHeader | input | 2 | Sync header of the input block |
| inPayload | input | 64 | Scrambled payload, bit 0 earliest on the line |
| bypassEn | input | 1 | Pass the payload through untouched |
| outValid | output | 1 | Output word strobe |
| outHeader | output | 2 | Sync header, unchanged |
| outPayload | output | 64 | Descrambled (or bypassed) payload |

## Verification
The bench goes after the first word after reset, which is descrambled from an all-zero history. A design that reversed the bit order or mis-indexed the taps would give a result there that differs from the serial model, and a design that seeded its history from output bits would never return to plaintext. Idle gaps between words catch a history that shifts on invalid cycles, because the words after the gap would come out garbled. Bypass runs followed by normal words catch a history that freezes during bypass, which would corrupt the first word after bypass. Headers of 00 and 11 catch any filtering or decoding of the header.

// File: rtl/descram_pkg.sv
package descram_pkg;
  localparam int PAYLOAD_W = 64;
  localparam int HDR_W     = 2;
  localparam int TAP_NEAR  = 39;
  localparam int TAP_FAR   = 58;

  typedef struct packed {
    logic advance;   // shift received bits into the history
    logic load;      // capture a new result into the output registers
    logic passThru;  // select the raw payload instead of the descrambled one
  } descram_strobe_t;
endpackage

// File: rtl/descram_ctrl.sv
module descram_ctrl
  import descram_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic            bypassEn,
  output descram_strobe_t strobe,
  output logic            outValid
);
  logic armQ;

  always_comb begin
    strobe.advance  = inValid;
    strobe.load     = inValid;
    strobe.passThru = bypassEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      armQ     <= 1'b0;
    end else begin
      outValid <= inValid;
      armQ     <= 1'b1;
    end
  end

  // R2
  outvalid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    armQ |-> (outValid == $past(inValid)));
endmodule

// File: rtl/descram_dp.sv
module descram_dp
  import descram_pkg::*;
#(
  parameter int PW     = PAYLOAD_W,
  parameter int HW     = HDR_W,
  parameter int NEAR   = TAP_NEAR,
  parameter int FAR    = TAP_FAR
) (
  input  logic            clk,
  input  logic            rstN,
  input  descram_strobe_t strobe,
  input  logic [HW-1:0]   inHeader,
  input  logic [PW-1:0]   inPayload,
  output logic [HW-1:0]   outHeader,
  output logic [PW-1:0]   outPayload
);
  localparam int SW = FAR;        // history length
  localparam int EW = SW + PW;    // history plus current word, in line order

  // histQ[0] is the most recently received scrambled bit
  logic [SW-1:0] histQ, histNext;
  logic [EW-1:0] lineBits;        // lineBits[k]: k-th bit in line order
  logic [PW-1:0] clearBits;
  logic [PW-1:0] resultBits;
  logic          armQ;

  genvar k;
  generate
    for (k = 0; k < EW; k++) begin : g_line
      if (k < SW) begin : g_old
        assign lineBits[k] = histQ[SW-1-k];
      end else begin : g_new
        assign lineBits[k] = inPayload[k-SW];
      end
    end
    for (k = 0; k < PW; k++) begin : g_bit
      assign clearBits[k] = inPayload[k] ^ lineBits[k+SW-NEAR] ^ lineBits[k+SW-FAR];
    end
    for (k = 0; k < SW; k++) begin : g_hist
      assign histNext[k] = lineBits[EW-1-k];
    end
  endgenerate

  assign resultBits = strobe.passThru ? inPayload : clearBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histQ      <= '0;
      outHeader  <= '0;
      outPayload <= '0;
      armQ       <= 1'b0;
    end else begin
      armQ <= 1'b1;
      if (strobe.advance) histQ <= histNext;
      if (strobe.load) begin
        outHeader  <= inHeader;
        outPayload <= resultBits;
      end
    end
  end

  // R3
  hdr_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armQ && $past(strobe.load)) |-> (outHeader == $past(inHeader)));
  // R7
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armQ && $past(strobe.load && strobe.passThru)) |-> (outPayload == $past(inPayload)));
  // R6
  state_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armQ && !$past(strobe.advance)) |-> $stable(histQ));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armQ && !$past(strobe.load)) |-> ($stable(outPayload) && $stable(outHeader)));
endmodule

// File: rtl/payload_descrambler.sv
module payload_descrambler
  import descram_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [HDR_W-1:0]     inHeader,
  input  logic [PAYLOAD_W-1:0] inPayload,
  input  logic                 bypassEn,
  output logic                 outValid,
  output logic [HDR_W-1:0]     outHeader,
  output logic [PAYLOAD_W-1:0] outPayload
);
  descram_strobe_t strobe;

  descram_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .bypassEn (bypassEn),
    .strobe   (strobe),
    .outValid (outValid)
  );

  descram_dp #(
    .PW   (PAYLOAD_W),
    .HW   (HDR_W),
    .NEAR (TAP_NEAR),
    .FAR  (TAP_FAR)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inHeader   (inHeader),
    .inPayload  (inPayload),
    .outHeader  (outHeader),
    .outPayload (outPayload)
  );
endmodule

// File: tb/payload_descrambler_tb.sv
module payload_descrambler_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  inHeader = '0;
  logic [63:0] inPayload = '0;
  logic        bypassEn = 1'b0;
  logic        outValid;
  logic [1:0]  outHeader;
  logic [63:0] outPayload;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [65:0] expQ[$];
  string       tagQ[$];
  logic [57:0] scSt = 58'h2A5_5A5A_1234_5678;  // scrambler state, arbitrary start
  logic [57:0] mdSt = '0;                        // serial model of the receiver
  int          wordsSinceReset = 0;
  logic [65:0] lastOut = '0;

  payload_descrambler u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inHeader(inHeader),
    .inPayload(inPayload), .bypassEn(bypassEn), .outValid(outValid),
    .outHeader(outHeader), .outPayload(outPayload)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // serial scrambler, bit 0 first on the line
  task automatic scramble(input logic [63:0] p, output logic [63:0] s);
    for (int i = 0; i < 64; i++) begin
      s[i] = p[i] ^ scSt[38] ^ scSt[57];
      scSt = {scSt[56:0], s[i]};
    end
  endtask

  // serial receiver model: history fed from received bits
  task automatic model(input logic [63:0] s, output logic [63:0] o);
    for (int i = 0; i < 64; i++) begin
      o[i] = s[i] ^ mdSt[38] ^ mdSt[57];
      mdSt = {mdSt[56:0], s[i]};
    end
  endtask

  task automatic sendWord(input logic [1:0] hdr, input logic [63:0] plain,
                          input bit byp, input string tag);
    logic [63:0] s, o, e;
    string t;
    scramble(plain, s);
    model(s, o);
    if (byp) begin e = s; t = {tag, " R7"}; end
    else if (wordsSinceReset >= 1) begin e = plain; t = {tag, " R5"}; end
    else begin e = o; t = {tag, " R4"}; end
    @(negedge clk);
    inValid = 1'b1; inHeader = hdr; inPayload = s; bypassEn = byp;
    expQ.push_back({hdr, e});
    tagQ.push_back(t);
    wordsSinceReset++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      inPayload = {$urandom, $urandom};
      inHeader = 2'($urandom);
      bypassEn = 1'($urandom);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; inValid = 1'b0; bypassEn = 1'b0;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && outHeader == 2'b0 && outPayload == 64'b0, "R1 reset",
          {outHeader, outPayload}, 66'b0);
    mdSt = '0;
    wordsSinceReset = 0;
    lastOut = '0;
    rstN = 1'b1;
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #2;
    if (rstN && !done) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected outValid", {outHeader, outPayload}, '0);
        end else begin
          logic [65:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check({outHeader, outPayload} == e, {t, " R3"}, {outHeader, outPayload}, e);
        end
      end else begin
        check({outHeader, outPayload} == lastOut, "R9 hold on idle",
              {outHeader, outPayload}, lastOut);
      end
      lastOut = {outHeader, outPayload};
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    // R4: first word from a zero history, then R5 lock-on
    sendWord(2'b01, 64'h0123_4567_89AB_CDEF, 0, "first");
    sendWord(2'b10, 64'h0, 0, "zeros");
    sendWord(2'b01, '1, 0, "ones");
    for (int i = 0; i < 20; i++) sendWord(2'($urandom), {$urandom, $urandom}, 0, "burst");
    // R3: invalid header codes pass untouched
    sendWord(2'b00, {$urandom, $urandom}, 0, "hdr00");
    sendWord(2'b11, {$urandom, $urandom}, 0, "hdr11");
    // R6: gaps
    idle(3);
    for (int i = 0; i < 10; i++) begin
      sendWord(2'b10, {$urandom, $urandom}, 0, "R6 gap");
      idle(i % 4);
    end
    // R7 then R8
    for (int i = 0; i < 5; i++) sendWord(2'b01, {$urandom, $urandom}, 1, "bypass");
    sendWord(2'b10, 64'hDEAD_BEEF_0BAD_F00D, 0, "R8 exit");
    idle(2);
    sendWord(2'b01, {$urandom, $urandom}, 1, "bypass1");
    sendWord(2'b01, {$urandom, $urandom}, 0, "R8 exit2");
    // R5: reset with the line scrambler left in its running state
    idle(1);
    repeat (3) @(negedge clk);
    doReset();
    sendWord(2'b10, {$urandom, $urandom}, 0, "post-reset");
    sendWord(2'b01, {$urandom, $urandom}, 0, "relock");
    for (int i = 0; i < 30; i++) sendWord(2'b10, {$urandom, $urandom}, i % 7 == 3, "mix");
    idle(4);
    check(expQ.size() == 0, "R2 all results delivered", 66'(expQ.size()), 66'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule